// File: doc/BRIEF.md
# Hash/Cipher Input Stream Router

This block takes a single stream of 32-bit words and sends each word to the input queue of a cipher engine, to the input queue of a hash engine, or to both. The choice depends on the packet's operation and on the word's position in the packet. Each queue holds sixteen words and has its own read and write pointers. The block also passes the cipher engine's results to a single output port. When the operation hashes the ciphertext, it copies those results into the hash queue as well. The engines themselves sit outside the block. They are reached only through valid/ready ports.

Software starts a packet with a control word. The control word sets four things: an operation, a byte length, and a leading-dword offset, plus a start bit. The offset sets how many leading words are hashed but not ciphered. A nonzero length bounds the packet, and its final word carries a last flag and a byte mask. A length of zero makes the packet open-ended. Such a packet ends only when the next control word arrives. That control word then places a terminator entry into the packet's queues. After the terminator, the block either starts the next packet or goes idle.

All streaming ports follow valid/ready rules. A word moves only in a cycle where valid and ready are both high. The block never drops a word. An input word waits until every queue it must enter has room. A cipher result waits while the output side is not ready, or while the hash queue cannot take the copy.

Top module: `hcr_top`

## Requirements
- R1: The operation code `cfg_op` selects the routing. 0 sends every word to the hash queue only, and 1 sends every word to the cipher queue only. 2 sends every word to the hash queue, and every word from the offset onward to the cipher queue as well. 3 sends the leading offset words to the hash queue and the rest to the cipher queue. Each queue delivers its entries in arrival order.
- R2: In operations 2 and 3, the first `cfg_off` words of a packet (word index below `cfg_off`) never enter the cipher queue. In operation 2 every word enters the hash queue. In operations 0 and 1 the offset has no effect.
- R3: Each queue holds 16 entries. `in_ready` is low whenever a queue that the next word must enter is full. An offered word then waits and is never lost.
- R4: For a nonzero `cfg_len` in bytes, the packet has ceil(len/4) words. The final word carries last=1. Its byte mask has bit i set for each valid byte i, where byte i is data bits 8i+7..8i. A remainder of 1, 2 or 3 gives 0001, 0011 or 0111, and a remainder of 0 gives 1111. Every other word has last=0 and mask 1111.
- R5: With `cfg_len`=0, words are accepted without limit. An accepted control word then places a terminator entry (last=1, mask 0000, data 0) into each queue the packet routes to as input. That is the hash queue for operations 0 and 2, and the cipher queue for operations 1, 2 and 3.
- R6: An accepted control word with `cfg_start`=0 leaves the block idle. In the idle state `in_ready` is low.
- R7: `cph_valid` is high only while `key_ready` is high. Words written before the key is ready stay buffered in the cipher queue.
- R8: Cipher results pass from `cres_*` to `out_*`. In operation 3 each accepted result is also pushed into the hash queue with mask 1111 and its own last flag. A result is held while the hash queue is full or an input word enters the hash queue in the same cycle.
- R9: `op_ready` is high when the block is idle. It is also high during an open-ended packet while every queue that needs a terminator has room. It is low during a bounded packet that is still in progress. The block ignores `cfg_we` while `op_ready` is low.
- R10: `in_ready` is low in any cycle where `cfg_we` is high.
- R11: After reset the block is idle: `op_ready`=1, `in_ready`=0, and both queue-side valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word strobe |
| cfg_start | input | 1 | 1: start a packet, 0: go idle |
| cfg_op | input | 2 | Operation code |
| cfg_len | input | 16 | Packet length in bytes, 0 = open-ended |
| cfg_off | input | 8 | Hash-only leading word count |
| key_ready | input | 1 | Cipher key available |
| op_ready | output | 1 | A control word can be taken |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted this cycle if valid |
| cph_valid | output | 1 | Cipher queue entry valid |
| cph_data | output | 32 | Cipher queue data |
| cph_be | output | 4 | Cipher queue byte mask |
| cph_last | output | 1 | Cipher queue last flag |
| cph_ready | input | 1 | Cipher engine takes entry |
| hsh_valid | output | 1 | Hash queue entry valid |
| hsh_data | output | 32 | Hash queue data |
| hsh_be | output | 4 | Hash queue byte mask |
| hsh_last | output | 1 | Hash queue last flag |
| hsh_ready | input | 1 | Hash engine takes entry |
| cres_valid | input | 1 | Cipher result valid |
| cres_data | input | 32 | Cipher result word |
| cres_last | input | 1 | Cipher result last flag |
| cres_ready | output | 1 | Cipher result accepted |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Output last flag |
| out_ready | input | 1 | Output consumer ready |

## Verification
If the word index or the offset comparison is wrong, the wrong queue receives a word. That shows up as a data mismatch on the hash or cipher port when that entry reaches the head of its queue. If a queue pointer is wrong, `in_ready` flips in the same cycle the count drifts, or a stale entry appears at the head. If the length arithmetic is wrong, the last flag or the mask on the final word is wrong. It also leaves `in_ready` and `op_ready` in the wrong state in the cycle after that word. A reference model compares every output on every cycle, so each of these faults is caught in the first cycle it reaches a port.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_HASH      = 2'd0,
    OP_CIPH      = 2'd1,
    OP_HASH_CIPH = 2'd2,
    OP_CIPH_HASH = 2'd3
  } op_e;

  typedef struct packed {
    logic              last;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } word_t;

  localparam int WORD_W = $bits(word_t);
endpackage

// File: rtl/hcr_fifo.sv
module hcr_fifo #(
  parameter int W     = 37,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/hcr_pkt_ctl.sv
module hcr_pkt_ctl
  import hcr_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_take,
  input  logic             cfg_start,
  input  op_e              cfg_op,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [OFF_W-1:0] cfg_off,
  input  logic             word_take,
  output logic             active,
  output logic             open_ended,
  output op_e              op,
  output logic             to_h,
  output logic             to_c,
  output logic             w_last,
  output logic [BE_W-1:0]  w_be
);
  localparam int RW = $clog2(BE_W);

  logic             act_q;
  op_e              op_q;
  logic [LEN_W-1:0] len_q, idx_q, nwords;
  logic [OFF_W-1:0] off_q;
  logic [RW-1:0]    rem;
  logic             pre_off;

  assign active     = act_q;
  assign op         = op_q;
  assign open_ended = (len_q == '0);
  assign rem        = len_q[RW-1:0];
  assign nwords     = (len_q >> RW) + LEN_W'(rem != '0);
  assign w_last     = !open_ended && (idx_q == nwords - 1'b1);
  assign pre_off    = idx_q < LEN_W'(off_q);

  always_comb begin
    unique case (op_q)
      OP_HASH:      begin to_h = 1'b1;    to_c = 1'b0;     end
      OP_CIPH:      begin to_h = 1'b0;    to_c = 1'b1;     end
      OP_HASH_CIPH: begin to_h = 1'b1;    to_c = !pre_off; end
      default:      begin to_h = pre_off; to_c = !pre_off; end
    endcase
  end

  always_comb begin
    for (int i = 0; i < BE_W; i++)
      w_be[i] = !w_last || (rem == '0) || (i < int'(rem));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      op_q  <= OP_HASH;
      len_q <= '0;
      off_q <= '0;
      idx_q <= '0;
    end else if (cfg_take) begin
      act_q <= cfg_start;
      if (cfg_start) begin
        op_q  <= cfg_op;
        len_q <= cfg_len;
        off_q <= cfg_off;
        idx_q <= '0;
      end
    end else if (word_take) begin
      if (w_last) act_q <= 1'b0;
      if (idx_q != '1) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/hcr_top.sv
module hcr_top
  import hcr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 16,
  parameter int OFF_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_start,
  input  logic [1:0]        cfg_op,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic              key_ready,
  output logic              op_ready,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              cph_valid,
  output logic [DATA_W-1:0] cph_data,
  output logic [BE_W-1:0]   cph_be,
  output logic              cph_last,
  input  logic              cph_ready,
  output logic              hsh_valid,
  output logic [DATA_W-1:0] hsh_data,
  output logic [BE_W-1:0]   hsh_be,
  output logic              hsh_last,
  input  logic              hsh_ready,
  input  logic              cres_valid,
  input  logic [DATA_W-1:0] cres_data,
  input  logic              cres_last,
  output logic              cres_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready
);
  logic active, open_ended, to_h, to_c, w_last;
  logic [BE_W-1:0] w_be;
  op_e  op;

  logic cfg_take, word_take, term_h, term_c;
  logic in_push_h, res_to_h, res_ok, res_push_h;
  logic h_push, h_full, h_empty, h_pop;
  logic c_push, c_full, c_empty, c_pop;
  word_t in_word, res_word, term_word, h_din, c_din, h_dout, c_dout;

  hcr_pkt_ctl #(.LEN_W(LEN_W), .OFF_W(OFF_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cfg_take(cfg_take), .cfg_start(cfg_start), .cfg_op(op_e'(cfg_op)),
    .cfg_len(cfg_len), .cfg_off(cfg_off), .word_take(word_take),
    .active(active), .open_ended(open_ended), .op(op),
    .to_h(to_h), .to_c(to_c), .w_last(w_last), .w_be(w_be)
  );

  // terminator targets of the packet being closed
  assign term_h   = active && open_ended && (op == OP_HASH || op == OP_HASH_CIPH);
  assign term_c   = active && open_ended && (op != OP_HASH);
  assign op_ready = !active || (open_ended && !(term_h && h_full) && !(term_c && c_full));
  assign cfg_take = cfg_we && op_ready;

  assign in_ready  = active && !cfg_we && !(to_h && h_full) && !(to_c && c_full);
  assign word_take = in_valid && in_ready;
  assign in_push_h = word_take && to_h;

  always_comb begin
    in_word   = '{last: w_last, be: w_be, data: in_data};
    res_word  = '{last: cres_last, be: '1, data: cres_data};
    term_word = '{last: 1'b1, be: '0, data: '0};
  end

  // cipher results: straight to the output, copied to hash in cipher-then-hash
  assign res_to_h   = (op == OP_CIPH_HASH);
  assign res_ok     = !res_to_h || (!h_full && !in_push_h);
  assign cres_ready = out_ready && res_ok;
  assign out_valid  = cres_valid && res_ok;
  assign out_data   = cres_data;
  assign out_last   = cres_last;
  assign res_push_h = cres_valid && cres_ready && res_to_h;

  assign h_push = in_push_h || res_push_h || (cfg_take && term_h);
  assign h_din  = in_push_h ? in_word : (res_push_h ? res_word : term_word);
  assign c_push = (word_take && to_c) || (cfg_take && term_c);
  assign c_din  = word_take ? in_word : term_word;

  assign cph_valid = !c_empty && key_ready;
  assign c_pop     = cph_valid && cph_ready;
  assign hsh_valid = !h_empty;
  assign h_pop     = hsh_valid && hsh_ready;

  hcr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_hfifo (
    .clk(clk), .rst_n(rst_n), .push(h_push), .din(h_din), .full(h_full),
    .pop(h_pop), .dout(h_dout), .empty(h_empty)
  );

  hcr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_cfifo (
    .clk(clk), .rst_n(rst_n), .push(c_push), .din(c_din), .full(c_full),
    .pop(c_pop), .dout(c_dout), .empty(c_empty)
  );

  assign hsh_data = h_dout.data;
  assign hsh_be   = h_dout.be;
  assign hsh_last = h_dout.last;
  assign cph_data = c_dout.data;
  assign cph_be   = c_dout.be;
  assign cph_last = c_dout.last;
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic cfg_start,
  input logic op_ready,
  input logic in_ready,
  input logic key_ready,
  input logic cph_valid,
  input logic h_push,
  input logic h_full,
  input logic c_push,
  input logic c_full
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_push |-> !h_full);

  p_no_overflow_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_push |-> !c_full);

  p_key_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cph_valid |-> key_ready);

  p_cfg_blocks_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !in_ready);

  p_idle_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && op_ready && !cfg_start) |=> !in_ready);
endmodule

bind hcr_top hcr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
  .op_ready(op_ready), .in_ready(in_ready), .key_ready(key_ready),
  .cph_valid(cph_valid), .h_push(h_push), .h_full(h_full),
  .c_push(c_push), .c_full(c_full)
);

// File: tb/tb_hcr_top.sv
module tb_hcr_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_we, cfg_start, key_ready;
  logic [1:0] cfg_op;
  logic [15:0] cfg_len;
  logic [7:0] cfg_off;
  logic op_ready, in_valid, in_ready;
  logic [31:0] in_data;
  logic cph_valid, cph_last, cph_ready, hsh_valid, hsh_last, hsh_ready;
  logic [31:0] cph_data, hsh_data, cres_data, out_data;
  logic [3:0] cph_be, hsh_be;
  logic cres_valid, cres_last, cres_ready, out_valid, out_last, out_ready;

  hcr_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
    .cfg_op(cfg_op), .cfg_len(cfg_len), .cfg_off(cfg_off), .key_ready(key_ready),
    .op_ready(op_ready), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cph_valid(cph_valid), .cph_data(cph_data), .cph_be(cph_be), .cph_last(cph_last),
    .cph_ready(cph_ready), .hsh_valid(hsh_valid), .hsh_data(hsh_data), .hsh_be(hsh_be),
    .hsh_last(hsh_last), .hsh_ready(hsh_ready), .cres_valid(cres_valid),
    .cres_data(cres_data), .cres_last(cres_last), .cres_ready(cres_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  int checks = 0, errors = 0;

  // behavioural reference state
  logic [36:0] qh[$], qc[$];
  bit m_act, m_took;
  int m_op, m_len, m_off, m_idx;
  int seq = 0, rseq = 0, accepted = 0;
  int pop_h = 0, pop_c = 0, term_h = 0, term_c = 0;
  logic [3:0] last_be_h = 4'h0, last_be_c = 4'h0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit hf, cf, open, pre, toh, toc, lastw, inr, th, tc, opr, iph, rok, hp, cp;
    int nw, rem;
    logic [3:0] be;
    logic [36:0] w;
    #1;
    hf = qh.size() >= DEPTH;
    cf = qc.size() >= DEPTH;
    open = (m_len == 0);
    pre = m_idx < m_off;
    toh = (m_op == 0) || (m_op == 2) || (m_op == 3 && pre);
    toc = (m_op == 1) || (m_op >= 2 && !pre);
    nw = (m_len + 3) / 4;
    lastw = !open && (m_idx == nw - 1);
    rem = m_len % 4;
    be = (!lastw || rem == 0) ? 4'hF : (4'hF >> (4 - rem));
    inr = m_act && !cfg_we && !(toh && hf) && !(toc && cf);
    th = m_act && open && (m_op == 0 || m_op == 2);
    tc = m_act && open && (m_op != 0);
    opr = !m_act || (open && !(th && hf) && !(tc && cf));
    iph = in_valid && inr && toh;
    rok = (m_op != 3) || (!hf && !iph);

    chk(in_ready == inr, "R3", "in_ready", in_ready, inr);
    if (cfg_we) chk(in_ready == 1'b0, "R10", "in_ready during cfg_we", in_ready, 0);
    chk(op_ready == opr, "R9", "op_ready", op_ready, opr);
    chk(cph_valid == (qc.size() > 0 && key_ready), "R7", "cph_valid", cph_valid,
        qc.size() > 0 && key_ready);
    if (cph_valid && qc.size() > 0)
      chk({cph_last, cph_be, cph_data} == qc[0], "R1", "cipher entry",
          {cph_last, cph_be, cph_data}, qc[0]);
    chk(hsh_valid == (qh.size() > 0), "R1", "hsh_valid", hsh_valid, qh.size() > 0);
    if (hsh_valid && qh.size() > 0)
      chk({hsh_last, hsh_be, hsh_data} == qh[0], "R2", "hash entry",
          {hsh_last, hsh_be, hsh_data}, qh[0]);
    chk(out_valid == (cres_valid && rok), "R8", "out_valid", out_valid, cres_valid && rok);
    chk(cres_ready == (out_ready && rok), "R8", "cres_ready", cres_ready, out_ready && rok);
    if (out_valid) chk(out_data == cres_data, "R8", "out_data", out_data, cres_data);

    hp = hsh_valid && hsh_ready && qh.size() > 0;
    cp = cph_valid && cph_ready && qc.size() > 0;
    if (hp) begin
      w = qh.pop_front(); pop_h++;
      if (w[36] && w[35:32] == 4'h0) term_h++; else if (w[36]) last_be_h = w[35:32];
    end
    if (cp) begin
      w = qc.pop_front(); pop_c++;
      if (w[36] && w[35:32] == 4'h0) term_c++; else if (w[36]) last_be_c = w[35:32];
    end
    w = {lastw, be, in_data};
    if (in_valid && inr) begin
      if (toh) qh.push_back(w);
      if (toc) qc.push_back(w);
      seq++; accepted++; m_idx++;
      if (lastw) m_act = 0;
    end
    if (cres_valid && out_ready && rok) begin
      if (m_op == 3) qh.push_back({cres_last, 4'hF, cres_data});
      rseq++;
    end
    m_took = cfg_we && opr;
    if (m_took) begin
      if (th) qh.push_back({1'b1, 4'h0, 32'h0});
      if (tc) qc.push_back({1'b1, 4'h0, 32'h0});
      m_act = cfg_start;
      if (cfg_start) begin
        m_op = cfg_op; m_len = cfg_len; m_off = cfg_off; m_idx = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n, int pv, int ph, int pc, int po);
    for (int i = 0; i < n; i++) begin
      in_valid   = ($urandom % 100) < pv;
      in_data    = 32'hA000_0000 + seq;
      hsh_ready  = ($urandom % 100) < ph;
      cph_ready  = ($urandom % 100) < pc;
      out_ready  = ($urandom % 100) < po;
      cres_valid = ($urandom % 100) < 50;
      cres_data  = 32'hC000_0000 + rseq;
      cres_last  = (rseq % 5) == 4;
      step();
    end
  endtask

  task automatic do_cfg(bit start, int op, int len, int off);
    int g = 0;
    m_took = 0;
    while (!m_took && g < 100) begin
      cfg_we = 1'b1; cfg_start = start; cfg_op = op[1:0];
      cfg_len = len[15:0]; cfg_off = off[7:0];
      in_valid = 1'b1; in_data = 32'hA000_0000 + seq;
      step();
      g++;
    end
    cfg_we = 1'b0;
  endtask

  task automatic wait_done();
    for (int g = 0; g < 3000 && m_act; g++) run(1, 90, 80, 80, 80);
  endtask

  task automatic drain();
    run(60, 0, 100, 100, 100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_start = 0; cfg_op = 0; cfg_len = 0; cfg_off = 0;
    key_ready = 1; in_valid = 0; in_data = 0; cph_ready = 0; hsh_ready = 0;
    cres_valid = 0; cres_data = 0; cres_last = 0; out_ready = 0;
    m_act = 0; m_op = 0; m_len = 0; m_off = 0; m_idx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(op_ready == 1'b1, "R11", "op_ready after reset", op_ready, 1);
    chk(in_ready == 1'b0, "R11", "in_ready after reset", in_ready, 0);
    chk(hsh_valid == 1'b0 && cph_valid == 1'b0, "R11", "queue valids after reset",
        {hsh_valid, cph_valid}, 0);
    @(negedge clk);

    // R4: hash-only bounded, 10 bytes -> 3 words, last mask 0011
    do_cfg(1, 0, 10, 0);
    wait_done();
    drain();
    chk(last_be_h == 4'b0011, "R4", "final mask hash", last_be_h, 4'b0011);
    chk(in_ready == 1'b0 && op_ready == 1'b1, "R4", "after bounded end",
        {in_ready, op_ready}, 2'b01);

    // R7: cipher-only, key absent: queue fills, nothing offered
    key_ready = 0;
    do_cfg(1, 1, 80, 0);
    run(30, 100, 100, 100, 100);
    chk(cph_valid == 1'b0, "R7", "cph_valid without key", cph_valid, 0);
    chk(in_ready == 1'b0, "R7", "input stalled by buffered words", in_ready, 0);
    key_ready = 1;
    wait_done();
    drain();

    // R2: hash+cipher, offset 2, 23 bytes -> 6 words, last mask 0111
    pop_h = 0; pop_c = 0;
    do_cfg(1, 2, 23, 2);
    wait_done();
    drain();
    chk(pop_h == 6, "R2", "hash entries", pop_h, 6);
    chk(pop_c == 4, "R2", "cipher entries after offset", pop_c, 4);
    chk(last_be_c == 4'b0111, "R4", "final mask cipher", last_be_c, 4'b0111);

    // R9: control word ignored mid bounded packet
    do_cfg(1, 0, 40, 0);
    run(3, 100, 100, 100, 100);
    chk(op_ready == 1'b0, "R9", "op_ready busy", op_ready, 0);
    cfg_we = 1; cfg_start = 1; cfg_op = 1; cfg_len = 4; cfg_off = 0;
    in_valid = 0;
    step();
    cfg_we = 0;
    wait_done();
    drain();

    // R3 + R5: open-ended hash-only, hash engine stalled
    accepted = 0;
    do_cfg(1, 0, 0, 0);
    run(30, 100, 0, 100, 100);
    chk(accepted == DEPTH, "R3", "words taken with full queue", accepted, DEPTH);
    chk(in_ready == 1'b0, "R3", "stall on full", in_ready, 0);
    run(5, 0, 100, 100, 100);
    term_h = 0;
    do_cfg(1, 3, 0, 1);
    drain();
    chk(term_h == 1, "R5", "hash terminator", term_h, 1);

    // R8 + R5 + R6: open-ended cipher-then-hash, then stop
    run(80, 70, 60, 60, 70);
    term_c = 0;
    do_cfg(0, 0, 0, 0);
    in_valid = 1;
    run(1, 100, 100, 100, 100);
    chk(in_ready == 1'b0, "R6", "idle after stop", in_ready, 0);
    drain();
    chk(term_c == 1, "R5", "cipher terminator", term_c, 1);

    // R1: cipher-only bounded with random back-pressure
    do_cfg(1, 1, 30, 5);
    wait_done();
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule